// File: doc/BRIEF.md
# Microwire Serial EEPROM Controller

This block is a hardware master for a three-wire serial EEPROM that stores 16-bit words. A host issues one command at a time through a strobe, a two-bit host opcode, an 8-bit word address and 16 bits of write data. The block then generates every device-side bit sequence by itself. It drives chip select, a serial clock and serial data out, and it samples serial data in. When the command ends, it pulses `done`, and read data is valid from that cycle onward.

A read is one short command frame followed by sixteen receive bit cells. A write is wrapped in two control frames: the block opens writes on the device, sends the full write frame, deselects, then reselects the device and watches the data-in line until the device reports that programming is complete. Last, it closes writes again. The ready wait is bounded by a timeout. If the timeout expires, the block raises a sticky error flag, closes writes anyway and completes the command instead of hanging. The host can also open or close writes on their own. The serial clock rate is set by a half-period parameter counted in system clocks.

Top module: `eeprom_mw_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves chip select low, serial clock low, serial data out low, `busy`, `done` and `timeout_err` low, and `rd_data` zero. The sequencer returns to idle.
- R2: Every high phase of the serial clock lasts exactly `HALF_CYC` system clocks. In a transmit cell the data bit is presented with the clock low for `HALF_CYC` cycles before the clock rises, and the clock stays low for `HALF_CYC` cycles after it falls.
- R3: Host opcode 2'b00 (read) sends 11 bits, most significant first: a 1 start bit, device opcode 2'b10, then the 8 address bits. It then clocks 16 receive cells with serial data out held at 0, sampling data-in at the end of each high phase. The sampled bits are assembled MSB first into `rd_data`, which is valid when `done` pulses.
- R4: Host opcode 2'b01 (write) first sends an 11-bit open frame (1, 0, 0, then eight 1s) and deselects. It then sends a 27-bit frame: 1, device opcode 2'b01, the address and the 16 data bits, MSB first. It then deselects again.
- R5: After the write frame, the block asserts chip select with no clock edges and polls data-in every system clock. Once data-in is high, it deselects and sends the 11-bit close frame (1 then ten 0s), then deselects.
- R6: If data-in stays low for `POLL_LIMIT` polling cycles, `timeout_err` is set and stays set until reset. The close frame is still sent and `done` still pulses.
- R7: `busy` rises in the cycle after an accepted strobe and stays high until the cycle in which `done` is high. In that cycle `busy` is low. `done` is a single-cycle pulse.
- R8: Command strobes that arrive while `busy` is high are ignored. They produce no device frame and do not change the command in progress.
- R9: Host opcode 2'b10 sends only the open frame, and 2'b11 sends only the close frame, each followed by a deselect.
- R10: The serial clock is never high while chip select is low. Between frames within a command, chip select stays low for at least `HALF_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted only while idle |
| cmd_op | input | 2 | Host opcode: 0 read, 1 write, 2 open writes, 3 close writes |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Word to program |
| rd_data | output | 16 | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Command in progress |
| timeout_err | output | 1 | Sticky ready-timeout flag |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sk | output | 1 | Serial clock to the device |
| ee_mosi | output | 1 | Serial data to the device |
| ee_miso | input | 1 | Serial data / ready indication from the device |

## Verification
A wrong bit counter or frame shift register shows up as a frame of the wrong length or content at the device pins. It also lands in the wrong word of the device model and appears at `rd_data` on the next read-back, within one command. A stuck or misrouted sequencer state appears as `busy` that never falls, a `done` pulse that comes without its frames, or a missing close frame, all visible before the next command starts. A broken phase counter changes the measured serial-clock high time on its first bit cell. A poll counter off by even a small margin is exposed by a device that never reports ready: either the error flag is missing or the command never completes.

// File: rtl/eemw_pkg.sv
package eemw_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int OP_W     = 2;
    localparam int CMD_BITS = 1 + OP_W + ADDR_W;
    localparam int FRAME_W  = CMD_BITS + DATA_W;
    localparam int BL_W     = $clog2(FRAME_W + 1);

    typedef logic [FRAME_W-1:0] frame_t;

    typedef enum logic [1:0] {
        HOP_READ  = 2'd0,
        HOP_WRITE = 2'd1,
        HOP_OPEN  = 2'd2,
        HOP_CLOSE = 2'd3
    } host_op_e;

    localparam logic [OP_W-1:0] DEV_OP_READ  = 2'b10;
    localparam logic [OP_W-1:0] DEV_OP_WRITE = 2'b01;
    localparam logic [OP_W-1:0] DEV_OP_CTRL  = 2'b00;

    typedef enum logic [1:0] {
        CELL_TX,
        CELL_RX,
        CELL_GAP
    } cell_kind_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_OPEN,
        SQ_OPEN_GAP,
        SQ_CMD,
        SQ_RECV,
        SQ_CMD_GAP,
        SQ_POLL,
        SQ_POLL_GAP,
        SQ_CLOSE,
        SQ_END_GAP
    } seq_state_e;

    typedef struct packed {
        host_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } host_cmd_t;

    // Left-aligned device frame: start bit, opcode, address, data.
    function automatic frame_t build_frame(input logic [OP_W-1:0] op,
                                           input logic [ADDR_W-1:0] addr,
                                           input logic [DATA_W-1:0] data);
        return {1'b1, op, addr, data};
    endfunction

    // Open (address all ones) or close (address all zeros) control frame.
    function automatic frame_t ctrl_frame(input logic open_writes);
        logic [ADDR_W-1:0] a;
        a = open_writes ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
        return {1'b1, DEV_OP_CTRL, a, {DATA_W{1'b0}}};
    endfunction

    // Index of the final phase of a bit cell.
    function automatic logic [1:0] last_phase(input cell_kind_e k);
        case (k)
            CELL_TX: return 2'd2;
            CELL_RX: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // Clock level for the phase after phase ph.
    function automatic logic level_after(input cell_kind_e k, input logic [1:0] ph);
        return (k == CELL_TX) && (ph == 2'd0);
    endfunction

endpackage

// File: rtl/eemw_bitcell.sv
module eemw_bitcell
    import eemw_pkg::*;
#(
    parameter int HALF_CYC = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  cell_kind_e kind,
    input  logic       tx_bit,
    input  logic       miso,
    output logic       sk,
    output logic       mosi,
    output logic       cell_done,
    output logic       rx_bit
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF_CYC - 1);

    logic             active;
    cell_kind_e       kind_q;
    logic [1:0]       ph;
    logic [CNT_W-1:0] cnt;
    logic             phase_end;

    assign phase_end = (cnt == CNT_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            kind_q    <= CELL_GAP;
            ph        <= 2'd0;
            cnt       <= '0;
            sk        <= 1'b0;
            mosi      <= 1'b0;
            cell_done <= 1'b0;
            rx_bit    <= 1'b0;
        end else begin
            cell_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    kind_q <= kind;
                    ph     <= 2'd0;
                    cnt    <= '0;
                    mosi   <= (kind == CELL_TX) ? tx_bit : 1'b0;
                    sk     <= (kind == CELL_RX);
                end
            end else if (phase_end) begin
                cnt <= '0;
                if (kind_q == CELL_RX && ph == 2'd0) begin
                    rx_bit <= miso;
                end
                if (ph == last_phase(kind_q)) begin
                    active    <= 1'b0;
                    sk        <= 1'b0;
                    cell_done <= 1'b1;
                end else begin
                    ph <= ph + 2'd1;
                    sk <= level_after(kind_q, ph);
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: the clock level is held for the whole of a phase.
    a_r2_sk_hold: assert property (@(posedge clk) disable iff (rst)
        (active && !phase_end) |=> $stable(sk));

    // R2: a cell never begins while the previous one is running.
    a_r2_single_cell: assert property (@(posedge clk) disable iff (rst)
        (active && !phase_end) |=> active);

endmodule

// File: rtl/eemw_seq.sv
module eemw_seq
    import eemw_pkg::*;
#(
    parameter int POLL_LIMIT = 2500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cell_done,
    input  logic              rx_bit,
    input  logic              miso,
    output logic              cs,
    output logic              go,
    output cell_kind_e        kind,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy,
    output logic              timeout_err
);
    localparam int PC_W = $clog2(POLL_LIMIT + 1);
    localparam logic [PC_W-1:0] POLL_END = PC_W'(POLL_LIMIT - 1);

    seq_state_e        state;
    host_cmd_t         cmd_q;
    frame_t            frame;
    logic [BL_W-1:0]   bits_left;
    logic [DATA_W-1:0] rx_shift;
    logic [PC_W-1:0]   poll_cnt;

    assign tx_bit = frame[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            cmd_q       <= '0;
            frame       <= '0;
            bits_left   <= '0;
            rx_shift    <= '0;
            poll_cnt    <= '0;
            cs          <= 1'b0;
            go          <= 1'b0;
            kind        <= CELL_GAP;
            rd_data     <= '0;
            done        <= 1'b0;
            busy        <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q.op    <= host_op_e'(cmd_op);
                        cmd_q.addr  <= cmd_addr;
                        cmd_q.wdata <= cmd_wdata;
                        busy        <= 1'b1;
                        cs          <= 1'b1;
                        go          <= 1'b1;
                        kind        <= CELL_TX;
                        bits_left   <= BL_W'(CMD_BITS);
                        case (host_op_e'(cmd_op))
                            HOP_READ: begin
                                frame <= build_frame(DEV_OP_READ, cmd_addr, '0);
                                state <= SQ_CMD;
                            end
                            HOP_CLOSE: begin
                                frame <= ctrl_frame(1'b0);
                                state <= SQ_CLOSE;
                            end
                            default: begin
                                frame <= ctrl_frame(1'b1);
                                state <= SQ_OPEN;
                            end
                        endcase
                    end
                end
                SQ_OPEN, SQ_CMD, SQ_CLOSE: begin
                    if (cell_done) begin
                        frame <= frame << 1;
                        if (bits_left != BL_W'(1)) begin
                            bits_left <= bits_left - 1'b1;
                            go        <= 1'b1;
                        end else if (state == SQ_CMD && cmd_q.op == HOP_READ) begin
                            bits_left <= BL_W'(DATA_W);
                            kind      <= CELL_RX;
                            go        <= 1'b1;
                            state     <= SQ_RECV;
                        end else begin
                            cs   <= 1'b0;
                            kind <= CELL_GAP;
                            go   <= 1'b1;
                            case (state)
                                SQ_OPEN: state <= SQ_OPEN_GAP;
                                SQ_CMD:  state <= SQ_CMD_GAP;
                                default: state <= SQ_END_GAP;
                            endcase
                        end
                    end
                end
                SQ_RECV: begin
                    if (cell_done) begin
                        rx_shift <= {rx_shift[DATA_W-2:0], rx_bit};
                        if (bits_left != BL_W'(1)) begin
                            bits_left <= bits_left - 1'b1;
                            go        <= 1'b1;
                        end else begin
                            cs    <= 1'b0;
                            kind  <= CELL_GAP;
                            go    <= 1'b1;
                            state <= SQ_END_GAP;
                        end
                    end
                end
                SQ_OPEN_GAP: begin
                    if (cell_done) begin
                        if (cmd_q.op == HOP_WRITE) begin
                            cs        <= 1'b1;
                            frame     <= build_frame(DEV_OP_WRITE, cmd_q.addr, cmd_q.wdata);
                            bits_left <= BL_W'(FRAME_W);
                            kind      <= CELL_TX;
                            go        <= 1'b1;
                            state     <= SQ_CMD;
                        end else begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= SQ_IDLE;
                        end
                    end
                end
                SQ_CMD_GAP: begin
                    if (cell_done) begin
                        cs       <= 1'b1;
                        poll_cnt <= '0;
                        state    <= SQ_POLL;
                    end
                end
                SQ_POLL: begin
                    if (miso || poll_cnt == POLL_END) begin
                        if (!miso) begin
                            timeout_err <= 1'b1;
                        end
                        cs    <= 1'b0;
                        kind  <= CELL_GAP;
                        go    <= 1'b1;
                        state <= SQ_POLL_GAP;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                SQ_POLL_GAP: begin
                    if (cell_done) begin
                        cs        <= 1'b1;
                        frame     <= ctrl_frame(1'b0);
                        bits_left <= BL_W'(CMD_BITS);
                        kind      <= CELL_TX;
                        go        <= 1'b1;
                        state     <= SQ_CLOSE;
                    end
                end
                SQ_END_GAP: begin
                    if (cell_done) begin
                        if (cmd_q.op == HOP_READ) begin
                            rd_data <= rx_shift;
                        end
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R1: reset leaves the device deselected and the host side quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!cs && !busy && !done && !timeout_err));

    // R7: done lasts a single cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: busy only ends together with done.
    a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7: done never overlaps busy.
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: the timeout flag is sticky.
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err);

    // R8: a strobe during a command leaves the latched command untouched.
    a_r8_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> $stable(cmd_q));

endmodule

// File: rtl/eeprom_mw_ctrl.sv
module eeprom_mw_ctrl
    import eemw_pkg::*;
#(
    parameter int HALF_CYC   = 125,
    parameter int POLL_LIMIT = 2500000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        busy,
    output logic        timeout_err,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_mosi,
    input  logic        ee_miso
);
    logic       cell_go;
    cell_kind_e cell_kind;
    logic       cell_tx;
    logic       cell_done;
    logic       cell_rx;

    eemw_seq #(
        .POLL_LIMIT (POLL_LIMIT)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .cell_done   (cell_done),
        .rx_bit      (cell_rx),
        .miso        (ee_miso),
        .cs          (ee_cs),
        .go          (cell_go),
        .kind        (cell_kind),
        .tx_bit      (cell_tx),
        .rd_data     (rd_data),
        .done        (done),
        .busy        (busy),
        .timeout_err (timeout_err)
    );

    eemw_bitcell #(
        .HALF_CYC (HALF_CYC)
    ) cell_i (
        .clk       (clk),
        .rst       (rst),
        .go        (cell_go),
        .kind      (cell_kind),
        .tx_bit    (cell_tx),
        .miso      (ee_miso),
        .sk        (ee_sk),
        .mosi      (ee_mosi),
        .cell_done (cell_done),
        .rx_bit    (cell_rx)
    );

    // R10: no clock edge reaches a deselected device.
    a_r10_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_sk);

    // R1: serial lines idle after reset.
    a_r1_lines_idle: assert property (@(posedge clk)
        rst |=> (!ee_sk && !ee_mosi));

endmodule

// File: tb/eeprom_mw_ctrl_tb_top.sv
module eeprom_mw_ctrl_tb_top;

    localparam int HALF     = 3;
    localparam int POLL     = 400;
    localparam int BUSY_CYC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_addr = 8'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic [15:0] rd_data;
    logic        done, busy, timeout_err;
    logic        ee_cs, ee_sk, ee_mosi;
    logic        miso_m = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // 250 MHz: a period of 4 time units read as ns
    always #2 clk = ~clk;

    eeprom_mw_ctrl #(.HALF_CYC(HALF), .POLL_LIMIT(POLL)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .done(done), .busy(busy), .timeout_err(timeout_err),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_mosi(ee_mosi), .ee_miso(miso_m)
    );

    // ---------------- device model ----------------
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    logic [31:0] fr_bits [64];
    int          fr_len [64];
    int          fr_n = 0;
    logic [31:0] bits = 0;
    int          ecnt = 0;
    bit          in_frame = 0;
    bit          we_en = 0;
    bit          wr_pending = 0;
    bit          stuck = 0;
    bit          rd_mode = 0;
    logic [15:0] rd_word = 0;

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 16'h0101) ^ 16'h5A3C;
    endfunction

    always @(posedge ee_sk) begin
        if (ee_cs === 1'b1) begin
            bits = {bits[30:0], ee_mosi};
            ecnt++;
            if (ecnt == 11 && bits[9:8] == 2'b10) begin
                rd_word = mem[bits[7:0]];
                rd_mode = 1;
            end
            if (rd_mode && ecnt >= 12 && ecnt <= 27) miso_m = rd_word[27-ecnt];
        end
    end

    always @(posedge ee_cs) begin
        if (ee_cs === 1'b1) begin
            in_frame = 1;
            ecnt = 0;
            bits = 0;
            rd_mode = 0;
            miso_m = 0;
            if (wr_pending) begin
                wr_pending = 0;
                if (!stuck) begin
                    repeat (BUSY_CYC) @(negedge clk);
                    miso_m = 1;
                end
            end
        end
    end

    always @(negedge ee_cs) begin
        if (in_frame) begin
            in_frame = 0;
            if (fr_n < 64) begin
                fr_len[fr_n] = ecnt;
                fr_bits[fr_n] = bits;
                fr_n++;
            end
            if (ecnt == 11 && bits[9:8] == 2'b00) begin
                if (bits[7:6] == 2'b11) we_en = 1;
                if (bits[7:6] == 2'b00) we_en = 0;
            end
            if (ecnt == 27 && bits[25:24] == 2'b01) begin
                if (we_en) mem[bits[23:16]] = bits[15:0];
                wr_pending = 1;
            end
        end
    end

    // ---------------- port monitors (R2, R10) ----------------
    int sk_hi_run = 0, sk_hi_min = 1000, sk_hi_max = 0;
    int cs_lo_run = 0, cs_lo_min = 1000;
    int cs_sk_bad = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ee_sk === 1'b1) sk_hi_run++;
            else if (sk_hi_run > 0) begin
                if (sk_hi_run < sk_hi_min) sk_hi_min = sk_hi_run;
                if (sk_hi_run > sk_hi_max) sk_hi_max = sk_hi_run;
                sk_hi_run = 0;
            end
            if (ee_cs !== 1'b1 && ee_sk === 1'b1) cs_sk_bad++;
            if (ee_cs === 1'b0 && busy === 1'b1) cs_lo_run++;
            else if (ee_cs === 1'b1) begin
                if (cs_lo_run > 0 && cs_lo_run < cs_lo_min) cs_lo_min = cs_lo_run;
                cs_lo_run = 0;
            end else cs_lo_run = 0;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_read(input logic [7:0] a);
        return {5'd0, 1'b1, 2'b10, a, 16'h0000};
    endfunction
    function automatic logic [31:0] f_write(input logic [7:0] a, input logic [15:0] d);
        return {5'd0, 1'b1, 2'b01, a, d};
    endfunction
    localparam logic [31:0] F_OPEN  = 32'h4FF;
    localparam logic [31:0] F_CLOSE = 32'h400;

    task automatic check_frame(input int i, input int len, input logic [31:0] b,
                               input string req);
        check(fr_len[i] == len, req, fr_len[i], len);
        check(fr_bits[i] == b, req, fr_bits[i], b);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] a,
                           input logic [15:0] d, input bit intrude,
                           output logic [15:0] rd);
        int  cyc;
        bit  busy_ok;
        fr_n = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 0;
        check(busy === 1'b1, "R7 busy after strobe", busy, 1);
        busy_ok = 1;
        cyc = 0;
        while (done !== 1'b1 && cyc < 20000) begin
            if (intrude && cyc == 4) begin
                cmd_valid = 1; cmd_op = 2'd1; cmd_addr = a; cmd_wdata = ~d;
            end else cmd_valid = 0;
            @(negedge clk);
            cyc++;
            if (done !== 1'b1 && busy !== 1'b1) busy_ok = 0;
        end
        cmd_valid = 0;
        check(done === 1'b1, "R7 done reached", done, 1);
        check(busy === 1'b0 && busy_ok, "R7 busy until done", busy, 0);
        rd = rd_data;
        @(negedge clk);
        check(done === 1'b0, "R7 done single cycle", done, 0);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(ee_cs === 0 && ee_sk === 0 && ee_mosi === 0, "R1 lines",
              {ee_cs, ee_sk, ee_mosi}, 0);
        check(busy === 0 && done === 0, "R1 flags", {busy, done}, 0);
        check(timeout_err === 0, "R1 err", timeout_err, 0);
        check(rd_data === 16'h0, "R1 rd_data", rd_data, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rd;
        void'($urandom(32'h2C5E_91A7));
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_word(i);
            shadow[i] = init_word(i);
        end
        do_reset();

        // R3 reads at both address extremes
        run_cmd(2'd0, 8'h00, 16'h0, 0, rd);
        check(rd == shadow[0], "R3 read 00", rd, shadow[0]);
        check(fr_n == 1, "R3 frame count", fr_n, 1);
        check_frame(0, 27, f_read(8'h00), "R3 read frame");
        run_cmd(2'd0, 8'hFF, 16'h0, 0, rd);
        check(rd == shadow[255], "R3 read FF", rd, shadow[255]);
        check_frame(0, 27, f_read(8'hFF), "R3 read frame FF");

        // R4, R5 write with full framing, then read back
        run_cmd(2'd1, 8'hA5, 16'hFFFF, 0, rd);
        shadow[8'hA5] = 16'hFFFF;
        check(fr_n == 4, "R4 write frame count", fr_n, 4);
        check_frame(0, 11, F_OPEN, "R4 open frame");
        check_frame(1, 27, f_write(8'hA5, 16'hFFFF), "R4 write frame");
        check_frame(2, 0, 0, "R5 poll select only");
        check_frame(3, 11, F_CLOSE, "R5 close frame");
        check(timeout_err === 0, "R5 no timeout", timeout_err, 0);
        run_cmd(2'd0, 8'hA5, 16'h0, 0, rd);
        check(rd == 16'hFFFF, "R4 read back", rd, 16'hFFFF);

        // R9 standalone open / close
        run_cmd(2'd2, 8'h12, 16'h1234, 0, rd);
        check(fr_n == 1, "R9 open count", fr_n, 1);
        check_frame(0, 11, F_OPEN, "R9 open only");
        check(we_en == 1, "R9 device opened", we_en, 1);
        run_cmd(2'd3, 8'h12, 16'h1234, 0, rd);
        check(fr_n == 1, "R9 close count", fr_n, 1);
        check_frame(0, 11, F_CLOSE, "R9 close only");
        check(we_en == 0, "R9 device closed", we_en, 0);
        run_cmd(2'd1, 8'h03, 16'h0000, 0, rd);
        shadow[3] = 16'h0000;
        run_cmd(2'd0, 8'h03, 16'h0, 0, rd);
        check(rd == 16'h0000, "R4 write after close", rd, 16'h0000);

        // R8 strobe during a read is ignored
        run_cmd(2'd0, 8'h40, 16'hBEEF, 1, rd);
        check(fr_n == 1, "R8 no extra frame", fr_n, 1);
        check(rd == shadow[8'h40], "R8 read intact", rd, shadow[8'h40]);
        run_cmd(2'd0, 8'h40, 16'h0, 0, rd);
        check(rd == shadow[8'h40], "R8 word unchanged", rd, shadow[8'h40]);

        // Random mix of reads and writes (R3, R4)
        for (int k = 0; k < 40; k++) begin
            logic [7:0]  a;
            logic [15:0] d;
            a = 8'($urandom_range(0, 15)) ^ 8'h50;
            d = 16'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                run_cmd(2'd1, a, d, 0, rd);
                shadow[a] = d;
                check_frame(1, 27, f_write(a, d), "R4 random write frame");
            end else begin
                run_cmd(2'd0, a, 16'h0, 0, rd);
                check(rd == shadow[a], "R3 random read", rd, shadow[a]);
            end
        end

        // R6 ready timeout
        stuck = 1;
        run_cmd(2'd1, 8'h77, 16'h1357, 0, rd);
        shadow[8'h77] = 16'h1357;
        stuck = 0;
        check(timeout_err === 1, "R6 err set", timeout_err, 1);
        check(fr_n == 4, "R6 frames on timeout", fr_n, 4);
        check_frame(3, 11, F_CLOSE, "R6 close still sent");
        run_cmd(2'd0, 8'h77, 16'h0, 0, rd);
        check(timeout_err === 1, "R6 err sticky", timeout_err, 1);
        check(rd == 16'h1357, "R6 later read", rd, 16'h1357);

        // R1 reset clears the sticky flag
        do_reset();

        // R2, R10 from the monitors
        check(sk_hi_min == HALF && sk_hi_max == HALF, "R2 sk high time",
              {sk_hi_min[15:0], sk_hi_max[15:0]}, {16'(HALF), 16'(HALF)});
        check(cs_sk_bad == 0, "R10 sk while deselected", cs_sk_bad, 0);
        check(cs_lo_min >= HALF && cs_lo_min < 1000, "R10 deselect gap", cs_lo_min, HALF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule